// File: doc/BRIEF.md
# Three-Space Memory Address Decoder

This block sits between a processor core and its memories. It takes 16-bit addresses tagged with one of three spaces: program (P), X data and Y data. For each access it picks the target: small on-chip RAM, a fixed table ROM, or a single shared external memory port. Each on-chip array and both ROM tables live inside the block. The ROM words are computed from their index rather than loaded from a file. A control bit must be set before the block drives the external port at all.

The external window is aliased in two ways, and address bit 15 chooses between them. In the low image, all three spaces land on the same external words and the space tag plays no part. In the high image, X and Y get separate 4K halves, with the space tag driving external address bit 12. P sees the whole 8K and so overlays both halves. Any external access also needs address bit 13 set and bit 14 clear.

There are two request channels. Channel A carries any space and can read or write. Channel B carries Y reads only, so an X read and a Y read can run in the same cycle. Channel A always wins the external port. A Y read that loses the port is parked and issued in the first later cycle that channel A leaves the port free.

Top module: `triSpaceDecoder`

## Requirements
- R1: While reset is held, aValid, bValid, bStall, romErr, extRd and extWr are all low, and the external-enable bit is cleared.
- R2: A channel-A P access with address 0x0000..0x01FF reaches the 512-word program RAM. A read returns the last written word on aRdata with aValid high, one clock after the request cycle.
- R3: X and Y accesses at 0x0000..0x00FF reach two separate 256-word RAMs, so the same address in X and in Y holds independent words.
- R4: X or Y reads at 0x0100+i (i = 0..255) return ROM words. The X word is {i, ~i, i XOR 0x5A}, as three bytes with the most significant first. The Y word is {(i*i) as 16 bits, ~i}.
- R5: A write to an X or Y ROM address leaves the ROM word unchanged. It sets romErr from the next clock, and romErr stays set until reset.
- R6: The external-enable bit is loaded from cfgExtEn while cfgWe is high. While it is clear, addresses in the external ranges act as unmapped (R9).
- R7: With external access enabled, an address whose bits [15:13] are 001 drives extAddr = addr[12:0] for any of P, X or Y (aSpace 0, 1, 2). A read pulses extRd in the request cycle and returns extRdata one clock later. A write pulses extWr with extWdata = aWdata.
- R8: With external access enabled, an address whose bits [15:13] are 101 maps as follows. P drives extAddr = addr[12:0]. X drives extAddr = {0, addr[11:0]} and Y drives extAddr = {1, addr[11:0]}; both X and Y require addr[12] = 0.
- R9: Every other address or space is unmapped. Examples are P 0x0200..0x1FFF, X/Y 0x0200..0x1FFF, X/Y 0xB000..0xBFFF, any address with bit 14 set, and aSpace = 3. Such a read returns zero one clock later. No strobe is raised, and a write changes nothing.
- R10: Channel B reads Y space alongside channel A, with results on bRdata and bValid one clock later. If both channels need the external port in one cycle, A is served. bStall is then high from the next cycle until B is issued, which happens in the first cycle A does not use the port, and bValid follows one clock after that. A bReq presented while bStall is high is ignored.
- R11: extRd and extWr are never high together, and extWdata is zero unless extWr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Load strobe for the external-enable bit |
| cfgExtEn | input | 1 | New value of the external-enable bit |
| aReq | input | 1 | Channel A request |
| aSpace | input | 2 | Channel A space: 0 P, 1 X, 2 Y, 3 none |
| aWe | input | 1 | Channel A write (1) or read (0) |
| aAddr | input | 16 | Channel A address |
| aWdata | input | 24 | Channel A write data |
| aRdata | output | 24 | Channel A read data |
| aValid | output | 1 | aRdata holds a new result |
| bReq | input | 1 | Channel B Y-space read request |
| bAddr | input | 16 | Channel B address |
| bRdata | output | 24 | Channel B read data |
| bValid | output | 1 | bRdata holds a new result |
| bStall | output | 1 | A channel B external read is parked |
| extAddr | output | 13 | External memory word address |
| extRd | output | 1 | External read strobe |
| extWr | output | 1 | External write strobe |
| extWdata | output | 24 | External write data |
| extRdata | input | 24 | External read data, valid in the strobe cycle |
| romErr | output | 1 | Sticky flag for a write into ROM |

## Verification
External strobes and addresses are combinational, so the bench checks them in the same cycle the request is driven, shortly after the falling edge. Read data from either channel is due exactly one clock after its request cycle. The driver queues each expected word when it issues the read, and a monitor compares it with aRdata or bRdata at the next falling edge on which the matching valid is high. A parked channel B read is due one clock after the cycle in which it is issued. bStall and romErr are registered, so the bench checks them one falling edge after the cycle that caused them.

// File: rtl/tsdPkg.sv
`timescale 1ns/1ps
package tsdPkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 24;
  localparam int EXT_AW   = 13;
  localparam int P_WORDS  = 512;
  localparam int XY_WORDS = 256;
  localparam int P_IW     = $clog2(P_WORDS);
  localparam int XY_IW    = $clog2(XY_WORDS);
  // address bits the decode depends on
  localparam int BIT_HALF = EXT_AW - 1;
  localparam int BIT_EXT  = EXT_AW;
  localparam int BIT_GAP  = EXT_AW + 1;
  localparam int BIT_IMG  = EXT_AW + 2;

  localparam logic [1:0] SP_P = 2'd0;
  localparam logic [1:0] SP_X = 2'd1;
  localparam logic [1:0] SP_Y = 2'd2;

  typedef enum logic [2:0] {
    TG_NONE, TG_PRAM, TG_XRAM, TG_XROM, TG_YRAM, TG_YROM, TG_EXT
  } tgtT;

  typedef struct packed {
    tgtT               tgt;
    logic [EXT_AW-1:0] extAddr;
  } decT;

  typedef struct packed {
    tgtT               aTgt;
    logic              aRd;
    logic              aWr;
    tgtT               bTgt;
    logic              bRd;
    logic              extRd;
    logic              extWr;
    logic [EXT_AW-1:0] extAddr;
  } strobeT;

  function automatic decT decodeAddr(input logic [1:0] sp,
                                     input logic [ADDR_W-1:0] a,
                                     input logic extEn);
    decT d;
    d.tgt = TG_NONE;
    d.extAddr = '0;
    if (sp == SP_P && a < ADDR_W'(P_WORDS)) begin
      d.tgt = TG_PRAM;
    end else if ((sp == SP_X || sp == SP_Y) && a < ADDR_W'(2 * XY_WORDS)) begin
      if (a < ADDR_W'(XY_WORDS)) d.tgt = (sp == SP_X) ? TG_XRAM : TG_YRAM;
      else                       d.tgt = (sp == SP_X) ? TG_XROM : TG_YROM;
    end else if (extEn && a[BIT_EXT] && !a[BIT_GAP] && sp != 2'd3) begin
      if (!a[BIT_IMG] || sp == SP_P) begin
        d.tgt = TG_EXT;
        d.extAddr = a[EXT_AW-1:0];
      end else if (!a[BIT_HALF]) begin
        d.tgt = TG_EXT;
        d.extAddr = {sp == SP_Y, a[BIT_HALF-1:0]};
      end
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] romXWord(input logic [7:0] i);
    return DATA_W'({i, ~i, i ^ 8'h5A});
  endfunction

  function automatic logic [DATA_W-1:0] romYWord(input logic [7:0] i);
    logic [15:0] sq;
    sq = 16'(i) * 16'(i);
    return DATA_W'({sq, ~i});
  endfunction
endpackage

// File: rtl/tsdCtrl.sv
`timescale 1ns/1ps
module tsdCtrl
  import tsdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgExtEn,
  input  logic              aReq,
  input  logic [1:0]        aSpace,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              bReq,
  input  logic [ADDR_W-1:0] bAddr,
  output strobeT            stb,
  output logic              bStall,
  output logic              romErr
);
  logic              extEnQ, pendQ, pendD, romErrQ;
  logic [EXT_AW-1:0] pendAddrQ, pendAddrD;
  decT               aDec, bDec;
  tgtT               aTgt;
  logic              aExt;

  always_comb begin
    aDec = decodeAddr(aSpace, aAddr, extEnQ);
    bDec = decodeAddr(SP_Y, bAddr, extEnQ);
    aTgt = aReq ? aDec.tgt : TG_NONE;
    aExt = (aTgt == TG_EXT);
  end

  always_comb begin
    stb = '0;
    stb.aTgt = aTgt;
    stb.aRd = aReq && !aWe;
    stb.aWr = aReq && aWe;
    stb.bTgt = TG_NONE;
    pendD = pendQ;
    pendAddrD = pendAddrQ;
    if (aExt) begin
      stb.extRd = !aWe;
      stb.extWr = aWe;
      stb.extAddr = aDec.extAddr;
    end
    if (pendQ) begin
      if (!aExt) begin
        stb.bTgt = TG_EXT;
        stb.bRd = 1'b1;
        stb.extRd = 1'b1;
        stb.extAddr = pendAddrQ;
        pendD = 1'b0;
      end
    end else if (bReq) begin
      if (bDec.tgt == TG_EXT && aExt) begin
        pendD = 1'b1;
        pendAddrD = bDec.extAddr;
      end else begin
        stb.bTgt = bDec.tgt;
        stb.bRd = 1'b1;
        if (bDec.tgt == TG_EXT) begin
          stb.extRd = 1'b1;
          stb.extAddr = bDec.extAddr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extEnQ <= 1'b0;
      pendQ <= 1'b0;
      pendAddrQ <= '0;
      romErrQ <= 1'b0;
    end else begin
      if (cfgWe) extEnQ <= cfgExtEn;
      pendQ <= pendD;
      pendAddrQ <= pendAddrD;
      if (aReq && aWe && (aTgt == TG_XROM || aTgt == TG_YROM)) romErrQ <= 1'b1;
    end
  end

  assign bStall = pendQ;
  assign romErr = romErrQ;

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.extRd || stb.extWr) |-> extEnQ);  // R6
endmodule

// File: rtl/tsdDatapath.sv
`timescale 1ns/1ps
module tsdDatapath
  import tsdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [P_IW-1:0]   aIdx,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [XY_IW-1:0]  bIdx,
  input  logic [DATA_W-1:0] extRdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aValid,
  output logic [DATA_W-1:0] bRdata,
  output logic              bValid,
  output logic [EXT_AW-1:0] extAddr,
  output logic              extRd,
  output logic              extWr,
  output logic [DATA_W-1:0] extWdata
);
  logic [DATA_W-1:0] pRam [P_WORDS];
  logic [1:0][DATA_W-1:0] bankA, bankB;
  logic [DATA_W-1:0] aMux, bMux;
  logic [XY_IW-1:0] aXyIdx;

  assign aXyIdx = aIdx[XY_IW-1:0];

  always_ff @(posedge clk) begin
    if (stb.aWr && stb.aTgt == TG_PRAM) pRam[aIdx] <= aWdata;
  end

  for (genvar g = 0; g < 2; g++) begin : gBank
    localparam tgtT MINE = (g == 0) ? TG_XRAM : TG_YRAM;
    logic [DATA_W-1:0] mem [XY_WORDS];
    always_ff @(posedge clk) begin
      if (stb.aWr && stb.aTgt == MINE) mem[aXyIdx] <= aWdata;
    end
    assign bankA[g] = mem[aXyIdx];
    assign bankB[g] = mem[bIdx];
  end

  always_comb begin
    case (stb.aTgt)
      TG_PRAM: aMux = pRam[aIdx];
      TG_XRAM: aMux = bankA[0];
      TG_YRAM: aMux = bankA[1];
      TG_XROM: aMux = romXWord(8'(aXyIdx));
      TG_YROM: aMux = romYWord(8'(aXyIdx));
      TG_EXT:  aMux = extRdata;
      default: aMux = '0;
    endcase
    case (stb.bTgt)
      TG_YRAM: bMux = bankB[1];
      TG_YROM: bMux = romYWord(8'(bIdx));
      TG_EXT:  bMux = extRdata;
      default: bMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRdata <= '0;
      aValid <= 1'b0;
      bRdata <= '0;
      bValid <= 1'b0;
    end else begin
      aValid <= stb.aRd;
      bValid <= stb.bRd;
      if (stb.aRd) aRdata <= aMux;
      if (stb.bRd) bRdata <= bMux;
    end
  end

  assign extAddr  = stb.extAddr;
  assign extRd    = stb.extRd;
  assign extWr    = stb.extWr;
  assign extWdata = stb.extWr ? aWdata : '0;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.aRd && stb.aTgt == TG_NONE) |=> (aRdata == '0));  // R9
endmodule

// File: rtl/triSpaceDecoder.sv
`timescale 1ns/1ps
module triSpaceDecoder
  import tsdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgExtEn,
  input  logic              aReq,
  input  logic [1:0]        aSpace,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aValid,
  input  logic              bReq,
  input  logic [ADDR_W-1:0] bAddr,
  output logic [DATA_W-1:0] bRdata,
  output logic              bValid,
  output logic              bStall,
  output logic [EXT_AW-1:0] extAddr,
  output logic              extRd,
  output logic              extWr,
  output logic [DATA_W-1:0] extWdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic              romErr
);
  strobeT stb;

  tsdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgExtEn(cfgExtEn),
    .aReq(aReq), .aSpace(aSpace), .aWe(aWe), .aAddr(aAddr),
    .bReq(bReq), .bAddr(bAddr), .stb(stb), .bStall(bStall), .romErr(romErr)
  );

  tsdDatapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .aIdx(aAddr[P_IW-1:0]), .aWdata(aWdata), .bIdx(bAddr[XY_IW-1:0]),
    .extRdata(extRdata), .aRdata(aRdata), .aValid(aValid),
    .bRdata(bRdata), .bValid(bValid), .extAddr(extAddr),
    .extRd(extRd), .extWr(extWr), .extWdata(extWdata)
  );

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && !aWe) |=> aValid);  // R2
  AST_ROM_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && aWe && aSpace == SP_X && aAddr >= 16'h0100 && aAddr <= 16'h01FF) |=> romErr);  // R5
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bStall) |-> bValid);  // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(extRd && extWr));  // R11
endmodule

// File: tb/triSpaceDecoder_bench.sv
`timescale 1ns/1ps
module triSpaceDecoder_bench;
  logic clk = 1'b0;
  logic rstN;
  logic cfgWe, cfgExtEn, aReq, aWe, bReq;
  logic [1:0] aSpace;
  logic [15:0] aAddr, bAddr;
  logic [23:0] aWdata, aRdata, bRdata, extWdata, extRdata;
  logic aValid, bValid, bStall, extRd, extWr, romErr;
  logic [12:0] extAddr;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [23:0] qA[$], qB[$];
  string tA[$], tB[$];

  always #2 clk = ~clk;

  triSpaceDecoder u_triSpaceDecoder (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgExtEn(cfgExtEn),
    .aReq(aReq), .aSpace(aSpace), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata),
    .aRdata(aRdata), .aValid(aValid), .bReq(bReq), .bAddr(bAddr),
    .bRdata(bRdata), .bValid(bValid), .bStall(bStall), .extAddr(extAddr),
    .extRd(extRd), .extWr(extWr), .extWdata(extWdata), .extRdata(extRdata),
    .romErr(romErr)
  );

  function automatic logic [23:0] extVal(input logic [12:0] a);
    return {a, 11'h2A5};
  endfunction
  assign extRdata = extVal(extAddr);

  function automatic logic [23:0] xRom(input int i);
    logic [7:0] b = i[7:0];
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [23:0] yRom(input int i);
    logic [7:0] b = i[7:0];
    int sq = i * i;
    return {sq[15:0], ~b};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    cfgWe = 0; cfgExtEn = 0; aReq = 0; aWe = 0; aSpace = 0; aAddr = 0;
    aWdata = 0; bReq = 0; bAddr = 0;
  endtask

  // kind: 0 no strobe, 1 read strobe, 2 write strobe
  task automatic chkStrobe(input int kind, input logic [12:0] ea, input logic [23:0] wd, input string tag);
    check(extRd == (kind == 1), {tag, " extRd"}, extRd, kind == 1);
    check(extWr == (kind == 2), {tag, " extWr"}, extWr, kind == 2);
    if (kind != 0) check(extAddr == ea, {tag, " extAddr"}, extAddr, ea);
    check(extWdata == ((kind == 2) ? wd : 24'h0), {tag, " extWdata R11"}, extWdata, (kind == 2) ? wd : 24'h0);
  endtask

  task automatic aOp(input logic [1:0] sp, input bit we, input logic [15:0] ad, input logic [23:0] wd,
                     input int kind, input logic [12:0] ea, input logic [23:0] exp, input string tag);
    @(negedge clk);
    aReq = 1; aSpace = sp; aWe = we; aAddr = ad; aWdata = wd;
    if (!we) begin qA.push_back(exp); tA.push_back(tag); end
    #1 chkStrobe(kind, ea, wd, tag);
    @(posedge clk); #1 clr();
  endtask

  task automatic setExt(input bit v);
    @(negedge clk); cfgWe = 1; cfgExtEn = v;
    @(posedge clk); #1 clr();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (aValid) begin
        if (qA.size() == 0) check(1'b0, "R2 unexpected aValid", 1, 0);
        else begin
          check(aRdata == qA[0], tA[0], aRdata, qA[0]);
          void'(qA.pop_front()); void'(tA.pop_front());
        end
      end
      if (bValid) begin
        if (qB.size() == 0) check(1'b0, "R10 unexpected bValid", 1, 0);
        else begin
          check(bRdata == qB[0], tB[0], bRdata, qB[0]);
          void'(qB.pop_front()); void'(tB.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    clr();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(aValid == 0, "R1 aValid", aValid, 0);
    check(bValid == 0, "R1 bValid", bValid, 0);
    check(bStall == 0, "R1 bStall", bStall, 0);
    check(romErr == 0, "R1 romErr", romErr, 0);
    check(!extRd && !extWr, "R1 strobes", {extRd, extWr}, 0);
    rstN = 1;

    // external disabled after reset
    aOp(2'd0, 0, 16'h2005, 0, 0, 0, 0, "R6 ext off read");
    aOp(2'd1, 1, 16'h2006, 24'h000001, 0, 0, 0, "R6 ext off write");

    // program RAM
    aOp(2'd0, 1, 16'h0000, 24'h111111, 0, 0, 0, "R2 wr lo");
    aOp(2'd0, 1, 16'h01FF, 24'h2222F2, 0, 0, 0, "R2 wr hi");
    aOp(2'd0, 0, 16'h0000, 0, 0, 0, 24'h111111, "R2 rd lo");
    aOp(2'd0, 0, 16'h01FF, 0, 0, 0, 24'h2222F2, "R2 rd hi");

    // X and Y RAM kept apart
    aOp(2'd1, 1, 16'h0010, 24'hAAAAAA, 0, 0, 0, "R3 wr x");
    aOp(2'd2, 1, 16'h0010, 24'h555555, 0, 0, 0, "R3 wr y");
    aOp(2'd1, 1, 16'h00FF, 24'h0C0FFE, 0, 0, 0, "R3 wr x top");
    aOp(2'd1, 0, 16'h0010, 0, 0, 0, 24'hAAAAAA, "R3 rd x");
    aOp(2'd2, 0, 16'h0010, 0, 0, 0, 24'h555555, "R3 rd y");
    aOp(2'd1, 0, 16'h00FF, 0, 0, 0, 24'h0C0FFE, "R3 rd x top");

    // ROM tables
    aOp(2'd1, 0, 16'h0100, 0, 0, 0, xRom(0), "R4 x rom 0");
    aOp(2'd1, 0, 16'h01FF, 0, 0, 0, xRom(255), "R4 x rom 255");
    aOp(2'd2, 0, 16'h0100, 0, 0, 0, yRom(0), "R4 y rom 0");
    aOp(2'd2, 0, 16'h01C3, 0, 0, 0, yRom(8'hC3), "R4 y rom c3");

    // ROM writes
    check(romErr == 0, "R5 romErr before", romErr, 0);
    aOp(2'd1, 1, 16'h0105, 24'hFFFFFF, 0, 0, 0, "R5 x rom wr");
    @(negedge clk);
    check(romErr == 1, "R5 romErr set", romErr, 1);
    aOp(2'd1, 0, 16'h0105, 0, 0, 0, xRom(5), "R5 x rom unchanged");
    aOp(2'd2, 1, 16'h0107, 24'h123456, 0, 0, 0, "R5 y rom wr");
    aOp(2'd2, 0, 16'h0107, 0, 0, 0, yRom(7), "R5 y rom unchanged");

    // unmapped
    aOp(2'd0, 0, 16'h0200, 0, 0, 0, 0, "R9 p 0200");
    aOp(2'd1, 0, 16'h0200, 0, 0, 0, 0, "R9 x 0200");
    aOp(2'd2, 0, 16'h1FFF, 0, 0, 0, 0, "R9 y 1fff");
    aOp(2'd3, 0, 16'h0000, 0, 0, 0, 0, "R9 space 3");
    aOp(2'd0, 1, 16'h0200, 24'hDEADBE, 0, 0, 0, "R9 p wr 0200");
    aOp(2'd0, 0, 16'h0000, 0, 0, 0, 24'h111111, "R9 p 0000 untouched");

    setExt(1);
    // low image: all spaces share
    aOp(2'd0, 0, 16'h2123, 0, 1, 13'h0123, extVal(13'h0123), "R7 p low");
    aOp(2'd1, 0, 16'h2123, 0, 1, 13'h0123, extVal(13'h0123), "R7 x low");
    aOp(2'd2, 0, 16'h2123, 0, 1, 13'h0123, extVal(13'h0123), "R7 y low");
    aOp(2'd1, 1, 16'h3FFF, 24'h13579B, 2, 13'h1FFF, 0, "R7 x low wr");

    // high image: split banks
    aOp(2'd0, 0, 16'hB456, 0, 1, 13'h1456, extVal(13'h1456), "R8 p high upper");
    aOp(2'd0, 0, 16'hA456, 0, 1, 13'h0456, extVal(13'h0456), "R8 p high lower");
    aOp(2'd1, 0, 16'hA456, 0, 1, 13'h0456, extVal(13'h0456), "R8 x high");
    aOp(2'd2, 0, 16'hA456, 0, 1, 13'h1456, extVal(13'h1456), "R8 y high");
    aOp(2'd2, 1, 16'hAFFF, 24'h00BEEF, 2, 13'h1FFF, 0, "R8 y high wr");

    // unmapped holes around the external window
    aOp(2'd1, 0, 16'hB000, 0, 0, 0, 0, "R9 x b000");
    aOp(2'd2, 0, 16'hB456, 0, 0, 0, 0, "R9 y b456");
    aOp(2'd0, 0, 16'h4000, 0, 0, 0, 0, "R9 p 4000");
    aOp(2'd0, 0, 16'hE000, 0, 0, 0, 0, "R9 p e000");
    aOp(2'd0, 0, 16'h1000, 0, 0, 0, 0, "R9 p 1000");

    // two channels on-chip together
    @(negedge clk);
    aReq = 1; aSpace = 2'd1; aAddr = 16'h0010; bReq = 1; bAddr = 16'h0010;
    qA.push_back(24'hAAAAAA); tA.push_back("R10 dual x");
    qB.push_back(24'h555555); tB.push_back("R10 dual y");
    #1 check(extRd == 0, "R10 dual no strobe", extRd, 0);
    @(posedge clk); #1 clr();
    @(negedge clk);
    check(bStall == 0, "R10 no stall on-chip", bStall, 0);
    bReq = 1; bAddr = 16'h0180;
    qB.push_back(yRom(8'h80)); tB.push_back("R10 b rom");
    @(posedge clk); #1 clr();
    @(negedge clk);
    bReq = 1; bAddr = 16'h2100;
    qB.push_back(extVal(13'h0100)); tB.push_back("R10 b ext alone");
    #1 check(extRd && extAddr == 13'h0100, "R10 b ext strobe", {extRd, extAddr}, {1'b1, 13'h0100});
    @(posedge clk); #1 clr();

    // conflict, port free next cycle
    @(negedge clk);
    aReq = 1; aSpace = 2'd1; aAddr = 16'h2010; bReq = 1; bAddr = 16'h2020;
    qA.push_back(extVal(13'h0010)); tA.push_back("R10 conflict a");
    qB.push_back(extVal(13'h0020)); tB.push_back("R10 conflict b");
    #1 check(extRd && extAddr == 13'h0010, "R10 a wins", {extRd, extAddr}, {1'b1, 13'h0010});
    @(posedge clk); #1 clr();
    @(negedge clk);
    check(bStall == 1, "R10 stall raised", bStall, 1);
    bReq = 1; bAddr = 16'h2030;
    #1 check(extRd && extAddr == 13'h0020, "R10 parked b issued", {extRd, extAddr}, {1'b1, 13'h0020});
    @(posedge clk); #1 clr();
    @(negedge clk);
    check(bStall == 0, "R10 stall cleared", bStall, 0);

    // conflict, A keeps the port one more cycle
    @(negedge clk);
    aReq = 1; aSpace = 2'd0; aAddr = 16'h2001; bReq = 1; bAddr = 16'h2002;
    qA.push_back(extVal(13'h0001)); tA.push_back("R10 conflict2 a");
    qB.push_back(extVal(13'h0002)); tB.push_back("R10 conflict2 b");
    @(posedge clk); #1 clr();
    @(negedge clk);
    aReq = 1; aSpace = 2'd1; aAddr = 16'h2003;
    qA.push_back(extVal(13'h0003)); tA.push_back("R10 a again");
    #1 check(extAddr == 13'h0003, "R10 a keeps port", extAddr, 13'h0003);
    check(bStall == 1, "R10 still parked", bStall, 1);
    @(posedge clk); #1 clr();
    @(negedge clk);
    #1 check(extRd && extAddr == 13'h0002, "R10 parked b late", {extRd, extAddr}, {1'b1, 13'h0002});
    @(posedge clk); #1 clr();

    // write on A against parked read on B
    @(negedge clk);
    aReq = 1; aWe = 1; aSpace = 2'd0; aAddr = 16'h2040; aWdata = 24'h777777;
    bReq = 1; bAddr = 16'h2050;
    qB.push_back(extVal(13'h0050)); tB.push_back("R10 b after a write");
    #1 check(extWr && !extRd && extAddr == 13'h0040, "R11 write alone", {extWr, extRd, extAddr}, {2'b10, 13'h0040});
    @(posedge clk); #1 clr();
    @(negedge clk);
    #1 check(extRd && !extWr && extAddr == 13'h0050, "R11 read alone", {extWr, extRd, extAddr}, {2'b01, 13'h0050});
    @(posedge clk); #1 clr();

    setExt(0);
    aOp(2'd0, 0, 16'h2000, 0, 0, 0, 0, "R6 disabled again");
    check(romErr == 1, "R5 sticky", romErr, 1);

    repeat (3) @(negedge clk);
    check(qA.size() == 0, "R2 a results outstanding", qA.size(), 0);
    check(qB.size() == 0, "R10 b results outstanding", qB.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule